// File: doc/BRIEF.md
# Merging write buffer

This block sits between a write-through cache and the memory below it. The cache hands over each store, one word at a time, and may carry on as soon as the buffer has taken it. The buffer holds up to `DEPTH` block entries. Each entry carries a block address, one data slot per word and one valid bit per word. A store whose block address matches an entry that is still waiting is folded into that entry. It does not take a fresh slot, so the buffer fills up, and stalls the cache, less often.

The buffer writes its entries to memory in the background, oldest first, one whole entry per handshake. The entry that is oldest is being written out, so no store merges into it. A store to that block opens a new entry. A read miss from the cache can look up the buffer combinationally before it goes to memory ahead of the pending writes. The lookup says whether the read may go ahead, whether the buffer can supply the word itself, or whether the read must wait until the writes to that block have drained.

Back-pressure rules. On the store port a word moves on a rising edge where `st_valid` and `st_ready` are both high. `st_ready` depends on the address being offered, so the cache must hold the store steady until it is taken. On the drain port the oldest entry moves on a rising edge where `dr_valid` and `dr_ready` are both high. While `dr_ready` is low the offered entry does not change.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `dr_valid`=0, `full`=0, `st_ready`=1 and `rd_status`=0 for any lookup.
- R2: A store to a block held by no waiting entry opens a new entry behind all others. That entry has only the stored word's mask bit set (mask bit w belongs to word w) and holds the stored data in word slot w, at bits w*DATA_W upward of `dr_data`.
- R3: A store whose block matches a waiting entry other than the oldest is merged into it. It sets that word's mask bit, overwrites that word's data and uses no new entry.
- R4: The oldest entry (the one on the drain port) accepts no merge. A store to its block opens a new entry, or stalls if no entry is free.
- R5: `full`=1 exactly when all `DEPTH` entries are occupied. While full, `st_ready` is 1 only if the offered store can merge into a waiting entry, and a store offered with `st_ready`=0 is not taken.
- R6: `dr_valid` is 1 whenever the buffer is not empty, and the drain port shows the oldest entry. Entries leave in the order they were opened, one per handshake, and the offered entry holds still while `dr_ready` is 0.
- R7: Word slots of `dr_data` whose mask bit is 0 read as zero.
- R8: A lookup (`rd_blk`, `rd_word`) whose word is valid in at least one entry of that block gives `rd_status`=1 and `rd_data` = that word from the youngest such entry.
- R9: A lookup whose block is present but whose word is valid in none of its entries gives `rd_status`=2 (the read must wait for the drain), with `rd_data`=0. The value 3 never appears.
- R10: A lookup whose block is in no entry gives `rd_status`=0 (the read may go ahead of the writes), with `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_blk | input | BLK_W | Block address of the store |
| st_word | input | $clog2(WORDS) | Word index within the block |
| st_data | input | DATA_W | Store data |
| full | output | 1 | All entries occupied |
| dr_valid | output | 1 | Oldest entry offered to memory |
| dr_ready | input | 1 | Memory accepts the offered entry |
| dr_blk | output | BLK_W | Block address of the offered entry |
| dr_mask | output | WORDS | Per-word valid bits of the offered entry |
| dr_data | output | WORDS*DATA_W | Word data of the offered entry, word 0 lowest |
| rd_blk | input | BLK_W | Block address of a read lookup |
| rd_word | input | $clog2(WORDS) | Word index of a read lookup |
| rd_status | output | 2 | 0 clear, 1 hit, 2 wait |
| rd_data | output | DATA_W | Word returned on a hit |

## Verification
The lookup outputs and `st_ready` are combinational on the current inputs and stored state, so they are due in the same cycle the inputs change. A taken store, merged or newly opened, shows on the drain port and in lookups from the first cycle after its accepting edge. A drain handshake exposes the next entry one cycle after its edge. The bench drives every input just after a falling edge, compares all outputs with a bench-side model 1 ns later, and advances the model only at the rising edge, using the handshakes the model itself predicts.

// File: rtl/merge_wbuf_pkg.sv
package merge_wbuf_pkg;
  // Result of a read-miss lookup against the buffered stores
  typedef enum logic [1:0] {
    LK_CLEAR = 2'd0,
    LK_HIT   = 2'd1,
    LK_WAIT  = 2'd2
  } lookup_e;
endpackage

// File: rtl/merge_wbuf_ring.sv
// Occupancy ring: head (oldest), tail (next free) and count.
// DEPTH must be a power of two so the pointers wrap naturally.
module merge_wbuf_ring #(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic [DEPTH-1:0] occ,
  output logic [DEPTH-1:0] at_head
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [PTR_W-1:0] age;
    assign age        = PTR_W'(i) - head;
    assign occ[i]     = {1'b0, age} < count;
    assign at_head[i] = (count != '0) && (head == PTR_W'(i));
  end
endmodule

// File: rtl/merge_wbuf_entry_cmp.sv
// Per-entry address comparison for store merging and read lookup.
module merge_wbuf_entry_cmp #(
  parameter int BLK_W = 6,
  parameter int WORDS = 4,
  localparam int WSEL_W = $clog2(WORDS)
) (
  input  logic              occ,
  input  logic              at_head,
  input  logic [BLK_W-1:0]  ent_blk,
  input  logic [WORDS-1:0]  ent_mask,
  input  logic [BLK_W-1:0]  st_blk,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic [WSEL_W-1:0] rd_word,
  output logic              merge_ok,
  output logic              rd_match,
  output logic              rd_have
);
  assign merge_ok = occ && !at_head && (ent_blk == st_blk);
  assign rd_match = occ && (ent_blk == rd_blk);
  assign rd_have  = rd_match && ent_mask[rd_word];
endmodule

// File: rtl/merge_wbuf_lookup.sv
// Chooses the merge target and resolves the read lookup, youngest entry last.
module merge_wbuf_lookup
  import merge_wbuf_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [PTR_W-1:0]        head,
  input  logic [DEPTH-1:0]        merge_ok,
  input  logic [DEPTH-1:0]        rd_match,
  input  logic [DEPTH-1:0]        rd_have,
  input  logic [DEPTH*DATA_W-1:0] word_data,
  output lookup_e                 status,
  output logic [DATA_W-1:0]       data,
  output logic                    merge_hit,
  output logic [PTR_W-1:0]        merge_idx
);
  logic             found_word;
  logic             found_blk;
  logic [PTR_W-1:0] idx;

  always_comb begin
    found_word = 1'b0;
    found_blk  = 1'b0;
    data       = '0;
    idx        = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PTR_W'(k);
      if (rd_match[idx]) found_blk = 1'b1;
      if (rd_have[idx]) begin
        found_word = 1'b1;
        data       = word_data[idx*DATA_W +: DATA_W];
      end
    end
    if (found_word)     status = LK_HIT;
    else if (found_blk) status = LK_WAIT;
    else                status = LK_CLEAR;
  end

  always_comb begin
    merge_hit = 1'b0;
    merge_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (merge_ok[i]) begin
        merge_hit = 1'b1;
        merge_idx = PTR_W'(i);
      end
    end
  end
endmodule

// File: rtl/merge_wbuf.sv
// Merging write buffer between a write-through cache and memory.
module merge_wbuf
  import merge_wbuf_pkg::*;
#(
  parameter int BLK_W  = 6,
  parameter int WORDS  = 4,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [BLK_W-1:0]  st_blk,
  input  logic [WSEL_W-1:0] st_word,
  input  logic [DATA_W-1:0] st_data,
  output logic              full,
  output logic              dr_valid,
  input  logic              dr_ready,
  output logic [BLK_W-1:0]  dr_blk,
  output logic [WORDS-1:0]  dr_mask,
  output logic [LINE_W-1:0] dr_data,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [1:0]        rd_status,
  output logic [DATA_W-1:0] rd_data
);
  logic [BLK_W-1:0]  blk_q  [DEPTH];
  logic [WORDS-1:0]  mask_q [DEPTH];
  logic [LINE_W-1:0] line_q [DEPTH];

  logic [PTR_W-1:0]        head, tail, merge_idx;
  logic [CNT_W-1:0]        count;
  logic [DEPTH-1:0]        occ, at_head, merge_ok, rd_match, rd_have;
  logic [DEPTH*DATA_W-1:0] word_data;
  logic                    merge_hit, st_take, push, pop;
  lookup_e                 status;

  assign full     = (count == CNT_W'(DEPTH));
  assign st_ready = merge_hit || !full;
  assign st_take  = st_valid && st_ready;
  assign push     = st_take && !merge_hit;
  assign dr_valid = (count != '0);
  assign pop      = dr_valid && dr_ready;

  merge_wbuf_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head(head), .tail(tail), .count(count), .occ(occ), .at_head(at_head)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    merge_wbuf_entry_cmp #(.BLK_W(BLK_W), .WORDS(WORDS)) u_cmp (
      .occ(occ[i]), .at_head(at_head[i]),
      .ent_blk(blk_q[i]), .ent_mask(mask_q[i]),
      .st_blk(st_blk), .rd_blk(rd_blk), .rd_word(rd_word),
      .merge_ok(merge_ok[i]), .rd_match(rd_match[i]), .rd_have(rd_have[i])
    );
    assign word_data[i*DATA_W +: DATA_W] = line_q[i][rd_word*DATA_W +: DATA_W];
  end

  merge_wbuf_lookup #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_lookup (
    .head(head), .merge_ok(merge_ok), .rd_match(rd_match), .rd_have(rd_have),
    .word_data(word_data), .status(status), .data(rd_data),
    .merge_hit(merge_hit), .merge_idx(merge_idx)
  );

  assign rd_status = status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        blk_q[i]  <= '0;
        mask_q[i] <= '0;
        line_q[i] <= '0;
      end
    end else if (st_take) begin
      if (merge_hit) begin
        mask_q[merge_idx][st_word]                  <= 1'b1;
        line_q[merge_idx][st_word*DATA_W +: DATA_W] <= st_data;
      end else begin
        blk_q[tail]  <= st_blk;
        mask_q[tail] <= WORDS'(1) << st_word;
        line_q[tail] <= LINE_W'(st_data) << (st_word * DATA_W);
      end
    end
  end

  assign dr_blk  = blk_q[head];
  assign dr_mask = mask_q[head];
  assign dr_data = line_q[head];
endmodule

// File: rtl/merge_wbuf_sva.sv
// Port-level properties of the merging write buffer.
module merge_wbuf_sva #(
  parameter int BLK_W  = 6,
  parameter int WORDS  = 4,
  parameter int DATA_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    st_valid,
  input logic                    st_ready,
  input logic                    full,
  input logic                    dr_valid,
  input logic                    dr_ready,
  input logic [BLK_W-1:0]        dr_blk,
  input logic [WORDS-1:0]        dr_mask,
  input logic [WORDS*DATA_W-1:0] dr_data,
  input logic [1:0]              rd_status
);
  a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_ready |=> dr_valid && $stable(dr_blk) && $stable(dr_mask) && $stable(dr_data));

  a_r6_full_offers: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> dr_valid);

  a_r5_room_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> st_ready);

  a_r1_empty_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_valid |-> (rd_status == 2'd0) && !full);

  a_r2_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready |=> dr_valid);

  a_r2_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid |-> dr_mask != '0);

  a_r9_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status != 2'd3);

  always_comb begin
    if (rst_n === 1'b1 && dr_valid === 1'b1) begin
      for (int w = 0; w < WORDS; w++) begin
        if (!dr_mask[w]) begin
          a_r7_idle_words: assert (dr_data[w*DATA_W +: DATA_W] == '0);
        end
      end
    end
  end
endmodule

bind merge_wbuf merge_wbuf_sva #(.BLK_W(BLK_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .full(full), .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_blk(dr_blk),
  .dr_mask(dr_mask), .dr_data(dr_data), .rd_status(rd_status)
);

// File: tb/merge_wbuf_bench.sv
`timescale 1ns/1ps
module merge_wbuf_bench;
  localparam int BLK_W  = 6;
  localparam int WORDS  = 4;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int WSEL_W = 2;
  localparam int LINE_W = WORDS * DATA_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              st_valid = 1'b0;
  logic              st_ready;
  logic [BLK_W-1:0]  st_blk = '0;
  logic [WSEL_W-1:0] st_word = '0;
  logic [DATA_W-1:0] st_data = '0;
  logic              full;
  logic              dr_valid;
  logic              dr_ready = 1'b0;
  logic [BLK_W-1:0]  dr_blk;
  logic [WORDS-1:0]  dr_mask;
  logic [LINE_W-1:0] dr_data;
  logic [BLK_W-1:0]  rd_blk = '0;
  logic [WSEL_W-1:0] rd_word = '0;
  logic [1:0]        rd_status;
  logic [DATA_W-1:0] rd_data;

  always #2.5 clk = ~clk;

  merge_wbuf #(.BLK_W(BLK_W), .WORDS(WORDS), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_merge_wbuf (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_blk(st_blk), .st_word(st_word), .st_data(st_data), .full(full),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_blk(dr_blk), .dr_mask(dr_mask),
    .dr_data(dr_data), .rd_blk(rd_blk), .rd_word(rd_word),
    .rd_status(rd_status), .rd_data(rd_data)
  );

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Model: index 0 is the oldest entry
  logic [BLK_W-1:0]  m_blk [DEPTH];
  logic [WORDS-1:0]  m_msk [DEPTH];
  logic [DATA_W-1:0] m_dat [DEPTH][WORDS];
  int                m_cnt = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic int merge_slot(input logic [BLK_W-1:0] b);
    for (int k = 1; k < m_cnt; k++) if (m_blk[k] == b) return k;
    return -1;
  endfunction

  function automatic logic exp_ready(input logic [BLK_W-1:0] b);
    return (merge_slot(b) >= 0) || (m_cnt < DEPTH);
  endfunction

  function automatic logic [LINE_W-1:0] m_line(input int k);
    logic [LINE_W-1:0] l = '0;
    for (int w = 0; w < WORDS; w++)
      if (m_msk[k][w]) l[w*DATA_W +: DATA_W] = m_dat[k][w];
    return l;
  endfunction

  task automatic cmp_all();
    logic [1:0]        es;
    logic [DATA_W-1:0] ed;
    logic              blk_seen;
    chk("R5 st_ready", st_ready, exp_ready(st_blk));
    chk("R5 full", full, m_cnt == DEPTH);
    chk("R6 dr_valid", dr_valid, m_cnt > 0);
    if (m_cnt > 0) begin
      chk("R6 dr_blk", dr_blk, m_blk[0]);
      chk("R3 dr_mask", dr_mask, m_msk[0]);
      chk("R7 dr_data", dr_data, m_line(0));
    end
    es = 2'd0; ed = '0; blk_seen = 1'b0;
    for (int k = 0; k < m_cnt; k++) begin
      if (m_blk[k] == rd_blk) begin
        blk_seen = 1'b1;
        if (m_msk[k][rd_word]) begin es = 2'd1; ed = m_dat[k][rd_word]; end
      end
    end
    if (es == 2'd0 && blk_seen) es = 2'd2;
    if (es == 2'd1)      chk("R8 rd_status hit", rd_status, es);
    else if (es == 2'd2) chk("R9 rd_status wait", rd_status, es);
    else                 chk("R10 rd_status clear", rd_status, es);
    chk("R8 rd_data", rd_data, ed);
  endtask

  task automatic probe();
    #1;
  endtask

  task automatic advance();
    bit take_st, take_dr;
    int s;
    cmp_all();
    take_st = st_valid && exp_ready(st_blk);
    take_dr = dr_ready && (m_cnt > 0);
    @(posedge clk);
    if (take_st) begin
      s = merge_slot(st_blk);
      if (s < 0) begin
        s = m_cnt;
        m_cnt++;
        m_blk[s] = st_blk;
        m_msk[s] = '0;
        for (int w = 0; w < WORDS; w++) m_dat[s][w] = '0;
      end
      m_msk[s][st_word] = 1'b1;
      m_dat[s][st_word] = st_data;
    end
    if (take_dr) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        m_blk[k] = m_blk[k+1];
        m_msk[k] = m_msk[k+1];
        for (int w = 0; w < WORDS; w++) m_dat[k][w] = m_dat[k+1][w];
      end
      m_cnt--;
    end
    @(negedge clk);
  endtask

  task automatic step();
    probe();
    advance();
  endtask

  task automatic store(input int b, input int w, input int d);
    st_valid = 1'b1;
    st_blk   = BLK_W'(b);
    st_word  = WSEL_W'(w);
    st_data  = DATA_W'(d);
    step();
    st_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL R6 watchdog: actual=timeout expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  logic [15:0] lf = 16'hACE1;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    probe();
    chk("R1 reset dr_valid", dr_valid, 0);
    chk("R1 reset full", full, 0);
    chk("R1 reset st_ready", st_ready, 1);
    chk("R1 reset rd_status", rd_status, 0);
    advance();

    // Merge versus the oldest entry
    store(5, 0, 'h11);
    store(5, 1, 'h22);
    store(5, 2, 'h33);
    store(5, 1, 'h44);
    rd_blk = 5; rd_word = 1;
    probe();
    chk("R2 head block", dr_blk, 5);
    chk("R4 head kept single word", dr_mask, 4'b0001);
    chk("R2 head data", dr_data, 32'h0000_0011);
    chk("R3 merged word status", rd_status, 1);
    chk("R3 merged word overwritten", rd_data, 'h44);
    advance();
    rd_word = 3;
    probe();
    chk("R9 absent word waits", rd_status, 2);
    chk("R9 wait data zero", rd_data, 0);
    dr_ready = 1'b1;
    advance();
    dr_ready = 1'b0;
    probe();
    chk("R3 merged mask", dr_mask, 4'b0110);
    chk("R3 merged data", dr_data, 32'h0033_4400);
    dr_ready = 1'b1;
    advance();
    dr_ready = 1'b0;
    probe();
    chk("R3 only two entries used", dr_valid, 0);
    advance();

    // Full buffer behaviour
    store(1, 0, 'hA1);
    store(2, 0, 'hA2);
    store(3, 0, 'hA3);
    store(4, 0, 'hA4);
    st_valid = 1'b1; st_blk = 9; st_word = 0; st_data = 'h99;
    probe();
    chk("R5 full flag", full, 1);
    chk("R5 stall when no merge", st_ready, 0);
    advance();
    advance();
    st_blk = 3; st_word = 2; st_data = 'hC3;
    probe();
    chk("R5 merge accepted while full", st_ready, 1);
    advance();
    st_blk = 1; st_word = 1; st_data = 'hB1;
    probe();
    chk("R4 oldest block refused while full", st_ready, 0);
    advance();
    st_valid = 1'b0;
    dr_ready = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      probe();
      chk("R6 drain order", dr_blk, k);
      advance();
    end
    probe();
    chk("R6 empty after drain", dr_valid, 0);
    advance();
    dr_ready = 1'b0;

    // Lookup sweep over a known pattern
    for (int b = 0; b < 3; b++)
      for (int w = 0; w <= b; w++) store(b, w, 16 * b + w + 1);
    store(0, 3, 'h5A);
    for (int b = 0; b < 8; b++)
      for (int w = 0; w < WORDS; w++) begin
        rd_blk = BLK_W'(b); rd_word = WSEL_W'(w);
        step();
      end
    rd_blk = 7; rd_word = 0;
    probe();
    chk("R10 unmatched block clear", rd_status, 0);
    chk("R10 clear data zero", rd_data, 0);
    advance();
    rd_blk = 0; rd_word = 3;
    probe();
    chk("R8 youngest entry supplies word", rd_data, 'h5A);
    advance();
    dr_ready = 1'b1;
    repeat (5) step();

    // Pseudo-random traffic on a few blocks
    for (int i = 0; i < 6000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      st_valid = lf[0];
      st_blk   = BLK_W'(lf[3:2]);
      st_word  = lf[5:4];
      st_data  = lf[13:6];
      dr_ready = i[9] ? lf[14] : (lf[14] & lf[15]);
      rd_blk   = BLK_W'(lf[9:7]);
      rd_word  = lf[11:10];
      step();
    end
    st_valid = 1'b0;
    dr_ready = 1'b1;
    repeat (6) step();
    probe();
    chk("R1 drained back to empty", dr_valid, 0);
    chk("R1 drained full clear", full, 0);
    advance();

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule